// File: doc/BRIEF.md
# Unsigned Carry-Save Row-Reduction Multiplier

This block multiplies two unsigned operands and returns the full-width product. The operands may have different widths. The narrower one is zero-extended to the larger width N, and the product is 2N bits wide, so it never overflows. The logic is purely combinational: a new product appears in the same cycle that the operands change, and the block holds no state.

For N of three or more, the block builds one shifted partial-product row for each multiplier bit. It then compresses the rows in passes of 3:2 carry-save adders. In every pass the rows are grouped in threes from the low end of the list. Each group is replaced, in place, by a sum row and a carry row, and any one or two rows left at the end go through unchanged. Passes repeat until two rows remain. A grouped carry-lookahead adder then adds those two rows. Eight rows take four carry-save layers (8, 6, 4, 3, 2). The one-bit and two-bit cases use dedicated small logic instead of the tree.

Top module: `csa_row_mult`

## Requirements
- R1: With 4-bit operands, prod_o equals the exact unsigned product a_i*b_i for every one of the 256 operand pairs.
- R2: When A_W and B_W differ, the narrower operand is zero-extended to N = max(A_W,B_W), prod_o is 2N bits wide, and prod_o equals the exact product.
- R3: Partial-product row i equals a_i gated by bit i of b_i, shifted left by i places with zeros in the low i bits. A one-hot b_i = 2^i therefore gives prod_o = a_i << i.
- R4: For every 3:2 stage, the sum row plus the carry row equals the sum of its three input rows modulo 2^(2N). The carry row carries weight one place above the sum row, and every row is clipped to 2N bits.
- R5: With 8-bit operands, prod_o equals the exact product, including the extreme operands 0xFF*0xFF = 0xFE01 and 0x80*0x80 = 0x4000.
- R6: With 16-bit operands, prod_o equals the exact product, including 0xFFFF*0xFFFF = 0xFFFE0001.
- R7: With 1-bit operands, prod_o[0] = a_i[0] & b_i[0] and prod_o[1] = 0.
- R8: With 2-bit operands, the product comes from the AND of the two low bits followed by a chain of two half adders, and it is exact for all 16 operand pairs.
- R9: If either operand is zero, prod_o is zero.
- R10: If b_i equals 1, prod_o equals a_i zero-extended to 2N bits.
- R11: prod_o follows a change on a_i or b_i with no clock edge in between, because the block holds no register.
- R12: The final adder's output equals the sum of the two surviving rows modulo 2^(2N). The carry from the top bit is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | A_W | Multiplicand, unsigned |
| b_i | input | B_W | Multiplier, unsigned; bit i selects partial-product row i |
| prod_o | output | 2*max(A_W,B_W) | Unsigned product |

## Verification
The block has no state, so a faulty row, a misplaced carry weight or a broken lookahead group shows on prod_o in the same evaluation as the operands that excite it. Such a fault stays hidden for any operand pair that keeps the faulty bits at zero. Zero operands in particular mask almost every fault. The stimulus therefore includes one-hot multipliers, which isolate single rows, and all-ones operands, which drive every carry-save carry and the full carry-lookahead chain. Exhaustive small widths and seeded random wide operands cover the remaining cases.

// File: rtl/csa_mult_pkg.sv
package csa_mult_pkg;

  function automatic int max_of(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  // rows left after one pass: each triple becomes two, leftovers pass
  function automatic int next_rows(input int r);
    return 2 * (r / 3) + (r % 3);
  endfunction

  function automatic int rows_at(input int n, input int lvl);
    int r;
    r = n;
    for (int k = 0; k < lvl; k++) begin
      if (r > 2) r = next_rows(r);
    end
    return r;
  endfunction

  function automatic int num_levels(input int n);
    int r;
    int l;
    r = n;
    l = 0;
    for (int k = 0; k < 64; k++) begin
      if (r > 2) begin
        r = next_rows(r);
        l++;
      end
    end
    return l;
  endfunction

endpackage

// File: rtl/csa_pp_gen.sv
module csa_pp_gen #(
  parameter int N   = 8,
  parameter int P_W = 2 * N
) (
  input  logic [N-1:0]            a_i,
  input  logic [N-1:0]            b_i,
  output logic [N-1:0][P_W-1:0]   rows_o
);

  for (genvar i = 0; i < N; i++) begin : g_row
    assign rows_o[i] = P_W'(a_i & {N{b_i[i]}}) << i;
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      AST_PP_ROW: assert ((rows_o[i] >> i) == P_W'(b_i[i] ? a_i : '0)) // R3
        else $error("pp row %0d shape", i);
      AST_PP_LOW_ZERO: assert ((rows_o[i] & ((P_W'(1) << i) - P_W'(1))) == '0) // R3
        else $error("pp row %0d low bits", i);
    end
  end

endmodule

// File: rtl/csa_row_add.sv
module csa_row_add #(
  parameter int P_W = 16
) (
  input  logic [P_W-1:0] x_i,
  input  logic [P_W-1:0] y_i,
  input  logic [P_W-1:0] z_i,
  output logic [P_W-1:0] sum_o,
  output logic [P_W-1:0] carry_o
);

  logic [P_W-1:0] maj;

  assign sum_o   = x_i ^ y_i ^ z_i;
  assign maj     = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
  // carry weighted one place up; top bit clipped
  assign carry_o = {maj[P_W-2:0], 1'b0};

  always_comb begin
    AST_CSA_SUM: assert (P_W'(sum_o + carry_o) == P_W'(x_i + y_i + z_i)) // R4
      else $error("carry-save sum mismatch");
  end

endmodule

// File: rtl/csa_cla_add.sv
module csa_cla_add #(
  parameter int W   = 16,
  parameter int GRP = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);

  localparam int NGRP  = (W + GRP - 1) / GRP;
  localparam int W_PAD = NGRP * GRP;

  logic [W_PAD-1:0] gen;
  logic [W_PAD-1:0] prp;
  logic [W_PAD-1:0] sum_pad;
  logic [NGRP:0]    blk_c;

  assign gen      = W_PAD'(a_i) & W_PAD'(b_i);
  assign prp      = W_PAD'(a_i) ^ W_PAD'(b_i);
  assign blk_c[0] = 1'b0;

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    logic         grp_g;
    logic         grp_p;
    logic [GRP:0] c_loc;

    always_comb begin
      grp_g = 1'b0;
      grp_p = 1'b1;
      for (int i = 0; i < GRP; i++) begin
        grp_g = gen[k*GRP+i] | (prp[k*GRP+i] & grp_g);
        grp_p = grp_p & prp[k*GRP+i];
      end
    end

    // group carry skips the in-group chain
    assign blk_c[k+1] = grp_g | (grp_p & blk_c[k]);

    always_comb begin
      c_loc[0] = blk_c[k];
      for (int i = 0; i < GRP; i++) begin
        c_loc[i+1] = gen[k*GRP+i] | (prp[k*GRP+i] & c_loc[i]);
      end
    end

    assign sum_pad[k*GRP +: GRP] = prp[k*GRP +: GRP] ^ c_loc[GRP-1:0];
  end

  assign sum_o = sum_pad[W-1:0];

  always_comb begin
    AST_CLA_SUM: assert (sum_o == W'(a_i + b_i)) // R12
      else $error("lookahead sum mismatch");
  end

endmodule

// File: rtl/csa_row_mult.sv
module csa_row_mult #(
  parameter int A_W     = 8,
  parameter int B_W     = 8,
  parameter int CLA_GRP = 4
) (
  input  logic [A_W-1:0]                             a_i,
  input  logic [B_W-1:0]                             b_i,
  output logic [2*((A_W > B_W) ? A_W : B_W)-1:0]     prod_o
);

  import csa_mult_pkg::*;

  localparam int N      = max_of(A_W, B_W);
  localparam int P_W    = 2 * N;
  localparam int LEVELS = num_levels(N);

  logic [N-1:0] a_ext;
  logic [N-1:0] b_ext;

  assign a_ext = N'(a_i);
  assign b_ext = N'(b_i);

  if (N == 1) begin : g_n1
    assign prod_o = {1'b0, a_ext[0] & b_ext[0]};
  end else if (N == 2) begin : g_n2
    logic x_lo, y_lo, c_mid, t_hi;
    assign x_lo      = a_ext[1] & b_ext[0];
    assign y_lo      = a_ext[0] & b_ext[1];
    assign t_hi      = a_ext[1] & b_ext[1];
    assign prod_o[0] = a_ext[0] & b_ext[0];
    assign prod_o[1] = x_lo ^ y_lo;
    assign c_mid     = x_lo & y_lo;
    assign prod_o[2] = c_mid ^ t_hi;
    assign prod_o[3] = c_mid & t_hi;
  end else begin : g_tree
    logic [N-1:0][P_W-1:0] stage [LEVELS+1];

    csa_pp_gen #(
      .N   (N),
      .P_W (P_W)
    ) u_pp (
      .a_i    (a_ext),
      .b_i    (b_ext),
      .rows_o (stage[0])
    );

    for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_lvl
      localparam int R   = rows_at(N, lvl);
      localparam int TRI = R / 3;
      localparam int REM = R % 3;
      localparam int OUT = 2 * TRI + REM;

      for (genvar g = 0; g < TRI; g++) begin : g_csa
        csa_row_add #(
          .P_W (P_W)
        ) u_csa (
          .x_i     (stage[lvl][3*g]),
          .y_i     (stage[lvl][3*g+1]),
          .z_i     (stage[lvl][3*g+2]),
          .sum_o   (stage[lvl+1][2*g]),
          .carry_o (stage[lvl+1][2*g+1])
        );
      end

      for (genvar j = 0; j < REM; j++) begin : g_pass
        assign stage[lvl+1][2*TRI+j] = stage[lvl][3*TRI+j];
      end

      for (genvar k = OUT; k < N; k++) begin : g_idle
        assign stage[lvl+1][k] = '0;
      end
    end

    csa_cla_add #(
      .W   (P_W),
      .GRP (CLA_GRP)
    ) u_cpa (
      .a_i   (stage[LEVELS][0]),
      .b_i   (stage[LEVELS][1]),
      .sum_o (prod_o)
    );
  end

  always_comb begin
    AST_ZERO_OPERAND: assert (!(a_i == '0 || b_i == '0) || prod_o == '0) // R9
      else $error("zero operand gave nonzero product");
    AST_UNIT_OPERAND: assert (!(b_i == B_W'(1)) || prod_o == P_W'(a_i)) // R10
      else $error("unit multiplier mismatch");
    AST_TOP_BIT_N1: assert (N != 1 || prod_o[P_W-1] == 1'b0) // R7
      else $error("1-bit product high bit set");
  end

endmodule

// File: tb/csa_row_mult_test.sv
module csa_row_mult_test;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [3:0]  a4 = '0, b4 = '0;   logic [7:0]  p4;
  logic [7:0]  a8 = '0, b8 = '0;   logic [15:0] p8;
  logic [15:0] a16 = '0, b16 = '0; logic [31:0] p16;
  logic        a1 = '0, b1 = '0;   logic [1:0]  p1;
  logic [1:0]  a2 = '0, b2 = '0;   logic [3:0]  p2;
  logic [7:0]  am = '0;            logic [4:0]  bm = '0;
  logic [15:0] pm;

  csa_row_mult #(.A_W(4),  .B_W(4))  uut    (.a_i(a4),  .b_i(b4),  .prod_o(p4));
  csa_row_mult #(.A_W(8),  .B_W(8))  u_w8   (.a_i(a8),  .b_i(b8),  .prod_o(p8));
  csa_row_mult #(.A_W(16), .B_W(16)) u_w16  (.a_i(a16), .b_i(b16), .prod_o(p16));
  csa_row_mult #(.A_W(1),  .B_W(1))  u_w1   (.a_i(a1),  .b_i(b1),  .prod_o(p1));
  csa_row_mult #(.A_W(2),  .B_W(2))  u_w2   (.a_i(a2),  .b_i(b2),  .prod_o(p2));
  csa_row_mult #(.A_W(8),  .B_W(5))  u_mix  (.a_i(am),  .b_i(bm),  .prod_o(pm));

  function automatic longint unsigned ref_mul(input longint unsigned x, input longint unsigned y);
    return x * y;
  endfunction

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R11: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e_a7c3));
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // idle state: all operands zero
    chk("R9 w4 zero", p4, 0);
    chk("R9 w16 zero", p16, 0);
    chk("R9 mix zero", pm, 0);

    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        @(posedge clk); a4 = 4'(x); b4 = 4'(y);
        @(negedge clk); chk("R1 w4 exhaustive", p4, ref_mul(x, y));
      end
    end

    for (int x = 0; x < 4; x++) begin
      for (int y = 0; y < 4; y++) begin
        @(posedge clk); a2 = 2'(x); b2 = 2'(y);
        @(negedge clk); chk("R8 w2 exhaustive", p2, ref_mul(x, y));
      end
    end

    for (int x = 0; x < 2; x++) begin
      for (int y = 0; y < 2; y++) begin
        @(posedge clk); a1 = 1'(x); b1 = 1'(y);
        @(negedge clk);
        chk("R7 w1 bit0", p1[0], x & y);
        chk("R7 w1 bit1", p1[1], 0);
      end
    end

    @(posedge clk); a8 = 8'hFF; b8 = 8'hFF;
    @(negedge clk); chk("R5 w8 max", p8, 16'hFE01);
    @(posedge clk); a8 = 8'h80; b8 = 8'h80;
    @(negedge clk); chk("R5 w8 msb", p8, 16'h4000);

    for (int i = 0; i < 8; i++) begin
      @(posedge clk); a8 = 8'hB7; b8 = 8'(1 << i);
      @(negedge clk); chk("R3 one-hot row", p8, ref_mul(8'hB7, 1 << i));
    end

    @(posedge clk); a8 = 8'h00; b8 = 8'h5A;
    @(negedge clk); chk("R9 w8 zero a", p8, 0);
    @(posedge clk); a16 = 16'hC3A5; b16 = 16'h0001;
    @(negedge clk); chk("R10 w16 unit", p16, 32'h0000C3A5);

    @(posedge clk); a16 = 16'hFFFF; b16 = 16'hFFFF;
    @(negedge clk);
    chk("R6 w16 max", p16, 32'hFFFE0001);
    chk("R4 all carries", p16, ref_mul(16'hFFFF, 16'hFFFF));
    @(posedge clk); a16 = 16'hFFFF; b16 = 16'h8001;
    @(negedge clk); chk("R12 long carry", p16, ref_mul(16'hFFFF, 16'h8001));

    for (int k = 0; k < 2000; k++) begin
      @(posedge clk); a8 = 8'($urandom); b8 = 8'($urandom);
      @(negedge clk); chk("R5 w8 random", p8, ref_mul(a8, b8));
    end

    for (int k = 0; k < 2000; k++) begin
      @(posedge clk); a16 = 16'($urandom); b16 = 16'($urandom);
      @(negedge clk); chk("R6 w16 random", p16, ref_mul(a16, b16));
    end

    @(posedge clk); am = 8'hFF; bm = 5'h1F;
    @(negedge clk); chk("R2 mix max", pm, 16'h1EE1);
    for (int k = 0; k < 500; k++) begin
      @(posedge clk); am = 8'($urandom); bm = 5'($urandom);
      @(negedge clk); chk("R2 mix random", pm, ref_mul(am, bm));
    end

    // change operands between edges; result must follow without a clock
    @(negedge clk);
    a8 = 8'h3C; b8 = 8'h11;
    #2 chk("R11 no clock", p8, 16'h03FC);
    a8 = 8'h9D; b8 = 8'hE2;
    #2 chk("R11 no clock", p8, ref_mul(8'h9D, 8'hE2));

    done = 1'b1;
    summary();
    $finish;
  end

endmodule